// File: doc/BRIEF.md
# Parallel RGB Display Timing Generator

This block produces the line and frame timing for a dot-clock driven parallel RGB panel. A horizontal counter steps once per pixel clock and a vertical counter steps once per line. Comparators against programmed widths and windows give the horizontal sync, vertical sync and data-enable outputs, plus a pixel-request strobe that leads data-enable by one clock so an upstream fetch path can present the pixel in time.

All timing values are loaded through a small write port. The wait counts are measured from the leading edge of the matching sync pulse, so they already include the sync width. A next-frame base address can be written at any time. It is copied into the current-address output on the first clock of each frame, and a one-cycle frame-start pulse marks that moment. Clearing the run bit does not cut a frame short: the generator finishes the frame in progress and only then drops its run status.

Top module: `rgb_timing_gen`

## Requirements
- R1: After reset, and whenever the generator is idle, sync and data-enable outputs sit at their inactive level (the inverse of their polarity bit), pixReq and frameStart are low, runStatus is low, and curBase is zero.
- R2: Register 1 holds the line period in pixel clocks in bits [CNT_W-1:0] and the hsync width in bits [16 +: CNT_W]. Hsync is active for exactly that width at the start of each line, and lines repeat every period clocks.
- R3: Register 2 holds the frame length in lines in the low field and the vsync width in lines in the high field. Vsync is active for width*period clocks, and a frame lasts lines*period clocks.
- R4: Register 3 holds the horizontal wait in the low field and the vertical wait in the high field. Register 4 holds the valid pixels per line in the low field and the active lines in the high field. Data-enable is active for the valid pixel count, starting hWait clocks after the hsync leading edge, and only on lines vWait through vWait+activeLines-1 counted from the vsync leading edge.
- R5: pixReq is active high and is asserted exactly one clock before each active data-enable clock.
- R6: Register 0 bits 2, 3 and 4 make hsync, vsync and data-enable active-high when set and active-low when clear. Bit 5 drives dotClkFalling to select the falling launch edge.
- R7: The generator starts only when register 0 has both run (bit 0) and sync-enable (bit 1) set. The first frame then begins at line 0, pixel 0, with a frameStart pulse.
- R8: When run is cleared mid-frame, runStatus stays high, no new frame starts, and runStatus falls on the clock after the last pixel clock of the frame in progress.
- R9: Register 5 holds the next base address. curBase takes that value on the same clock that frameStart is high and does not change at any other time.
- R10: A period shorter than the sum of its parts wraps the counter early, at period minus one, and the windows beyond it are truncated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register index |
| wrData | input | DATA_W | Register write data |
| hsyncOut | output | 1 | Horizontal sync, polarity per register 0 bit 2 |
| vsyncOut | output | 1 | Vertical sync, polarity per register 0 bit 3 |
| deOut | output | 1 | Data enable, polarity per register 0 bit 4 |
| pixReq | output | 1 | Pixel request, one clock ahead of data enable |
| frameStart | output | 1 | One-clock pulse on the first clock of each frame |
| dotClkFalling | output | 1 | Launch pixel data on the falling dot-clock edge |
| runStatus | output | 1 | Generator running, including the drain of a final frame |
| curBase | output | BASE_W | Base address of the frame being shown |

## Verification
The bench builds the block with CNT_W=12 and BASE_W=24 and programs a 20-clock line and an 11-line frame. That way every edge of a whole frame, 220 clocks, is counted and placed exactly: sync widths, the data-enable origin at clock 86 and the drain end at clock 219. The 24-bit base width lets a swap value above 16 bits be checked. A later change of the line period to 10 clocks, below its parts, exercises the early wrap and the truncated data window.

// File: rtl/rgb_timing_pkg.sv
package rgb_timing_pkg;

  localparam int REG_ADDR_W = 3;

  localparam logic [REG_ADDR_W-1:0] ADDR_CTRL   = 3'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_HORIZ  = 3'd1;
  localparam logic [REG_ADDR_W-1:0] ADDR_VERT   = 3'd2;
  localparam logic [REG_ADDR_W-1:0] ADDR_WAIT   = 3'd3;
  localparam logic [REG_ADDR_W-1:0] ADDR_ACTIVE = 3'd4;
  localparam logic [REG_ADDR_W-1:0] ADDR_BASE   = 3'd5;

  localparam int CTRL_W       = 6;
  localparam int BIT_RUN      = 0;
  localparam int BIT_SYNC_EN  = 1;
  localparam int BIT_HS_HIGH  = 2;
  localparam int BIT_VS_HIGH  = 3;
  localparam int BIT_DE_HIGH  = 4;
  localparam int BIT_FALLING  = 5;

  typedef enum logic [1:0] {
    GEN_IDLE  = 2'd0,
    GEN_RUN   = 2'd1,
    GEN_DRAIN = 2'd2
  } genState_e;

  typedef struct packed {
    logic active;
    logic frameStart;
  } genStrobe_t;

endpackage

// File: rtl/rgb_timing_ctrl.sv
module rgb_timing_ctrl
  import rgb_timing_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       runReq,
  input  logic       syncEn,
  input  logic       frameEnd,
  input  logic       atOrigin,
  output genStrobe_t strb,
  output logic       runStatus
);

  genState_e state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      GEN_IDLE: begin
        if (runReq && syncEn) stateNext = GEN_RUN;
      end
      GEN_RUN: begin
        if (!runReq) stateNext = frameEnd ? GEN_IDLE : GEN_DRAIN;
      end
      GEN_DRAIN: begin
        if (runReq)        stateNext = GEN_RUN;
        else if (frameEnd) stateNext = GEN_IDLE;
      end
      default: stateNext = GEN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= GEN_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strb.active     = (state != GEN_IDLE);
    strb.frameStart = (state != GEN_IDLE) && atOrigin;
  end

  assign runStatus = (state != GEN_IDLE);

endmodule

// File: rtl/rgb_timing_dp.sv
module rgb_timing_dp
  import rgb_timing_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  parameter int BASE_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [REG_ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0]     wrData,
  input  genStrobe_t            strb,
  output logic                  runReq,
  output logic                  syncEn,
  output logic                  frameEnd,
  output logic                  atOrigin,
  output logic                  hsyncOut,
  output logic                  vsyncOut,
  output logic                  deOut,
  output logic                  pixReq,
  output logic                  frameStartOut,
  output logic                  dotClkFalling,
  output logic [BASE_W-1:0]     curBase,
  output logic [CTRL_W-1:0]     ctrlWord,
  output logic [BASE_W-1:0]     nextBaseWord
);

  localparam int HALF   = DATA_W / 2;
  localparam int EXT_W  = CNT_W + 1;
  localparam int N_SYNC = 3;
  localparam logic [EXT_W-1:0] ONE_EXT = EXT_W'(1);

  logic [CTRL_W-1:0] ctrlReg;
  logic [CNT_W-1:0]  hPeriod, hsWidth, vLines, vsWidth;
  logic [CNT_W-1:0]  hWait, vWait, hActive, vActive;
  logic [BASE_W-1:0] nextBase;

  // register write port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      hPeriod  <= '0;
      hsWidth  <= '0;
      vLines   <= '0;
      vsWidth  <= '0;
      hWait    <= '0;
      vWait    <= '0;
      hActive  <= '0;
      vActive  <= '0;
      nextBase <= '0;
    end else if (wrEn) begin
      unique case (wrAddr)
        ADDR_CTRL:   ctrlReg <= wrData[CTRL_W-1:0];
        ADDR_HORIZ: begin
          hPeriod <= wrData[CNT_W-1:0];
          hsWidth <= wrData[HALF +: CNT_W];
        end
        ADDR_VERT: begin
          vLines  <= wrData[CNT_W-1:0];
          vsWidth <= wrData[HALF +: CNT_W];
        end
        ADDR_WAIT: begin
          hWait <= wrData[CNT_W-1:0];
          vWait <= wrData[HALF +: CNT_W];
        end
        ADDR_ACTIVE: begin
          hActive <= wrData[CNT_W-1:0];
          vActive <= wrData[HALF +: CNT_W];
        end
        ADDR_BASE:   nextBase <= wrData[BASE_W-1:0];
        default: ;
      endcase
    end
  end

  // pixel and line counters
  logic [CNT_W-1:0] hCnt, vCnt;
  logic             hWrap, vWrap;

  assign hWrap    = ({1'b0, hCnt} + ONE_EXT) >= {1'b0, hPeriod};
  assign vWrap    = ({1'b0, vCnt} + ONE_EXT) >= {1'b0, vLines};
  assign frameEnd = hWrap && vWrap;
  assign atOrigin = (hCnt == '0) && (vCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (!strb.active) begin
      hCnt <= '0;
      vCnt <= '0;
    end else begin
      hCnt <= hWrap ? '0 : hCnt + 1'b1;
      if (hWrap) vCnt <= vWrap ? '0 : vCnt + 1'b1;
    end
  end

  // window decode
  logic hInWin, vInWin, drive;
  logic [EXT_W-1:0] hWinEnd, vWinEnd;

  assign hWinEnd = {1'b0, hWait} + {1'b0, hActive};
  assign vWinEnd = {1'b0, vWait} + {1'b0, vActive};
  assign hInWin  = (hCnt >= hWait) && ({1'b0, hCnt} < hWinEnd);
  assign vInWin  = (vCnt >= vWait) && ({1'b0, vCnt} < vWinEnd);
  assign drive   = strb.active && ctrlReg[BIT_SYNC_EN];
  assign pixReq  = drive && hInWin && vInWin;

  // polarity-applied output registers: 0 hsync, 1 vsync, 2 data enable
  logic [N_SYNC-1:0] rawAct, polHigh, outReg;

  assign rawAct  = {pixReq, drive && (vCnt < vsWidth), drive && (hCnt < hsWidth)};
  assign polHigh = {ctrlReg[BIT_DE_HIGH], ctrlReg[BIT_VS_HIGH], ctrlReg[BIT_HS_HIGH]};

  generate
    for (genvar i = 0; i < N_SYNC; i++) begin : g_syncOut
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) outReg[i] <= 1'b1;
        else       outReg[i] <= rawAct[i] ^ ~polHigh[i];
      end
    end
  endgenerate

  assign hsyncOut = outReg[0];
  assign vsyncOut = outReg[1];
  assign deOut    = outReg[2];

  // frame start pulse and base address swap
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameStartOut <= 1'b0;
      curBase       <= '0;
    end else begin
      frameStartOut <= strb.frameStart;
      if (strb.frameStart) curBase <= nextBase;
    end
  end

  assign runReq        = ctrlReg[BIT_RUN];
  assign syncEn        = ctrlReg[BIT_SYNC_EN];
  assign dotClkFalling = ctrlReg[BIT_FALLING];
  assign ctrlWord      = ctrlReg;
  assign nextBaseWord  = nextBase;

endmodule

// File: rtl/rgb_timing_gen.sv
module rgb_timing_gen
  import rgb_timing_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  parameter int BASE_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [REG_ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0]     wrData,
  output logic                  hsyncOut,
  output logic                  vsyncOut,
  output logic                  deOut,
  output logic                  pixReq,
  output logic                  frameStart,
  output logic                  dotClkFalling,
  output logic                  runStatus,
  output logic [BASE_W-1:0]     curBase
);

  genStrobe_t        strb;
  logic              runReq, syncEn, frameEnd, atOrigin;
  logic [CTRL_W-1:0] ctrlWord;
  logic [BASE_W-1:0] nextBaseWord;

  rgb_timing_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .runReq    (runReq),
    .syncEn    (syncEn),
    .frameEnd  (frameEnd),
    .atOrigin  (atOrigin),
    .strb      (strb),
    .runStatus (runStatus)
  );

  rgb_timing_dp #(
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W),
    .BASE_W (BASE_W)
  ) i_dp (
    .clk           (clk),
    .rstN          (rstN),
    .wrEn          (wrEn),
    .wrAddr        (wrAddr),
    .wrData        (wrData),
    .strb          (strb),
    .runReq        (runReq),
    .syncEn        (syncEn),
    .frameEnd      (frameEnd),
    .atOrigin      (atOrigin),
    .hsyncOut      (hsyncOut),
    .vsyncOut      (vsyncOut),
    .deOut         (deOut),
    .pixReq        (pixReq),
    .frameStartOut (frameStart),
    .dotClkFalling (dotClkFalling),
    .curBase       (curBase),
    .ctrlWord      (ctrlWord),
    .nextBaseWord  (nextBaseWord)
  );

endmodule

// File: rtl/rgb_timing_chk.sv
module rgb_timing_chk
  import rgb_timing_pkg::*;
#(
  parameter int BASE_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              runStatus,
  input logic              frameStart,
  input logic              pixReq,
  input logic              hsyncOut,
  input logic              vsyncOut,
  input logic              deOut,
  input logic [BASE_W-1:0] curBase,
  input logic [CTRL_W-1:0] ctrlWord,
  input logic [BASE_W-1:0] nextBaseWord
);

  // R1
  idle_outputs_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!runStatus && !$past(runStatus)) |->
      (hsyncOut == !$past(ctrlWord[BIT_HS_HIGH]) &&
       vsyncOut == !$past(ctrlWord[BIT_VS_HIGH]) &&
       deOut    == !$past(ctrlWord[BIT_DE_HIGH]) &&
       !pixReq && !frameStart));

  // R5
  pixreq_lead_chk: assert property (@(posedge clk) disable iff (!rstN)
    pixReq |=> (deOut == $past(ctrlWord[BIT_DE_HIGH])));

  // R7
  start_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(runStatus) |-> $past(ctrlWord[BIT_RUN] && ctrlWord[BIT_SYNC_EN]));

  // R7
  first_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(runStatus) |=> frameStart);

  // R8
  stop_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(runStatus) |-> !$past(ctrlWord[BIT_RUN]));

  // R9
  base_swap_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> (curBase == $past(nextBaseWord)));

  // R9
  base_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !frameStart |-> $stable(curBase));

endmodule

bind rgb_timing_gen rgb_timing_chk #(.BASE_W(BASE_W)) i_chk (
  .clk          (clk),
  .rstN         (rstN),
  .runStatus    (runStatus),
  .frameStart   (frameStart),
  .pixReq       (pixReq),
  .hsyncOut     (hsyncOut),
  .vsyncOut     (vsyncOut),
  .deOut        (deOut),
  .curBase      (curBase),
  .ctrlWord     (ctrlWord),
  .nextBaseWord (nextBaseWord)
);

// File: tb/test_rgb_timing_gen.sv
module test_rgb_timing_gen;

  localparam int CNT_W  = 12;
  localparam int DATA_W = 32;
  localparam int BASE_W = 24;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrEn = 1'b0;
  logic [2:0]        wrAddr = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic              hsyncOut, vsyncOut, deOut, pixReq, frameStart;
  logic              dotClkFalling, runStatus;
  logic [BASE_W-1:0] curBase;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  rgb_timing_gen #(.CNT_W(CNT_W), .DATA_W(DATA_W), .BASE_W(BASE_W)) i_rgb_timing_gen (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .hsyncOut(hsyncOut), .vsyncOut(vsyncOut), .deOut(deOut), .pixReq(pixReq),
    .frameStart(frameStart), .dotClkFalling(dotClkFalling),
    .runStatus(runStatus), .curBase(curBase)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] addr, input logic [31:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = addr; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitFrameStart(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (frameStart) begin seen = 1'b1; break; end
    end
  endtask

  task automatic measureFrame(input string tag, input logic hp, vp, dp,
                              input int expLen, expHs, expVs, expDe,
                              expFirstDe, expFirstPr);
    int hs = 0, vs = 0, de = 0, pr = 0, fde = -1, fpr = -1, fsMid = 0;
    bit seen;
    waitFrameStart(seen);
    chk("R9", {tag, " frame start seen"}, int'(seen), 1);
    for (int i = 0; i < expLen; i++) begin
      if (i > 0) @(negedge clk);
      if (hsyncOut == hp) hs++;
      if (vsyncOut == vp) vs++;
      if (deOut == dp) begin de++; if (fde < 0) fde = i; end
      if (pixReq) begin pr++; if (fpr < 0) fpr = i; end
      if (i > 0 && frameStart) fsMid++;
    end
    @(negedge clk);
    chk("R2", {tag, " hsync active clocks"}, hs, expHs);
    chk("R3", {tag, " vsync active clocks"}, vs, expVs);
    chk("R3", {tag, " frame length"}, int'(frameStart), 1);
    chk("R9", {tag, " no mid-frame start"}, fsMid, 0);
    chk("R4", {tag, " data-enable clocks"}, de, expDe);
    chk("R4", {tag, " first data-enable clock"}, fde, expFirstDe);
    chk("R5", {tag, " pixel requests"}, pr, expDe);
    chk("R5", {tag, " first pixel request"}, fpr, expFirstPr);
  endtask

  task automatic testReset();
    chk("R1", "reset hsync", int'(hsyncOut), 1);
    chk("R1", "reset vsync", int'(vsyncOut), 1);
    chk("R1", "reset de", int'(deOut), 1);
    chk("R1", "reset pixReq", int'(pixReq), 0);
    chk("R1", "reset frameStart", int'(frameStart), 0);
    chk("R1", "reset runStatus", int'(runStatus), 0);
    chk("R1", "reset curBase", int'(curBase), 0);
  endtask

  task automatic testNominal();
    regWrite(3'd1, (32'd3 << 16) | 32'd20);
    regWrite(3'd2, (32'd2 << 16) | 32'd11);
    regWrite(3'd3, (32'd4 << 16) | 32'd6);
    regWrite(3'd4, (32'd5 << 16) | 32'd8);
    regWrite(3'd5, 32'h1234);
    regWrite(3'd0, 32'h1F);
    measureFrame("nominal", 1'b1, 1'b1, 1'b1, 220, 33, 40, 40, 86, 85);
    chk("R9", "first frame base", int'(curBase), 32'h1234);
  endtask

  task automatic testPolarity();
    regWrite(3'd0, 32'h2B);
    measureFrame("polarity", 1'b0, 1'b1, 1'b0, 220, 33, 40, 40, 86, 85);
    chk("R6", "falling edge select", int'(dotClkFalling), 1);
  endtask

  task automatic testDrain();
    bit seen;
    int fallIdx = -1, fsSeen = 0, statusAfterWrite = 0;
    waitFrameStart(seen);
    for (int i = 1; i < 400; i++) begin
      @(negedge clk);
      if (i == 50) begin wrEn = 1'b1; wrAddr = 3'd0; wrData = 32'h2A; end
      if (i == 51) wrEn = 1'b0;
      if (i == 55) statusAfterWrite = int'(runStatus);
      if (frameStart) fsSeen++;
      if (!runStatus) begin fallIdx = i; break; end
    end
    chk("R8", "running after run cleared", statusAfterWrite, 1);
    chk("R8", "no new frame during drain", fsSeen, 0);
    chk("R8", "run status fall clock", fallIdx, 219);
    repeat (5) @(negedge clk);
    chk("R1", "idle hsync inactive", int'(hsyncOut), 1);
    chk("R1", "idle vsync inactive", int'(vsyncOut), 0);
    chk("R1", "idle de inactive", int'(deOut), 1);
    chk("R1", "idle pixReq", int'(pixReq), 0);
  endtask

  task automatic testSyncGate();
    bit seen;
    regWrite(3'd0, 32'h29);
    repeat (30) @(negedge clk);
    chk("R7", "no start without sync enable", int'(runStatus), 0);
    chk("R7", "vsync held inactive", int'(vsyncOut), 0);
    chk("R7", "no pixel request", int'(pixReq), 0);
    regWrite(3'd0, 32'h1F);
    waitFrameStart(seen);
    chk("R7", "start once sync enabled", int'(seen), 1);
    chk("R7", "run status after start", int'(runStatus), 1);
  endtask

  task automatic testBaseSwap();
    bit seen;
    int early = 0;
    logic [BASE_W-1:0] held;
    waitFrameStart(seen);
    held = curBase;
    chk("R9", "base before swap", int'(held), 32'h1234);
    regWrite(3'd5, 32'hABCDE);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (frameStart) break;
      if (curBase != held) early++;
    end
    chk("R9", "base held until frame start", early, 0);
    chk("R9", "base swapped at frame start", int'(curBase), 32'hABCDE);
  endtask

  task automatic testEarlyWrap();
    regWrite(3'd1, (32'd3 << 16) | 32'd10);
    measureFrame("early wrap R10", 1'b1, 1'b1, 1'b1, 110, 33, 20, 20, 46, 45);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testNominal();
    testPolarity();
    testDrain();
    testSyncGate();
    testBaseSwap();
    testEarlyWrap();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule